// File: doc/BRIEF.md
# Programmable Interval Timer with Expiry Flag

The block is an 8-bit down-counter that sits on a simple peripheral bus. The bus has a chip select, a 4-bit address, a read/write strobe and separate 8-bit write and read data. A write to a timer-load address loads the count. The same write picks how many bus cycles pass between decrements: 1, 8, 64 or 1024, chosen by the low address bits. A read returns either the current count or a status byte that carries the expiry flag.

When the count steps down from zero to 0xFF, the expiry flag is set and the timer then decrements on every bus cycle until software acknowledges it. Software acknowledges the expiry with a count read or a fresh load. The acknowledge clears the flag, and counting carries on from the value reached, at the programmed interval. There is one exception: an access that lands on the exact cycle of the wraparound leaves the flag set. Reading the status does not clear the flag, so polling the status is free of races.

One address bit selects the interrupt-enabled variant of each load or count-read address. When that enable is active and the flag is set, an active-low interrupt output is pulled low. All decrements and all bus accesses take effect only on cycles where the one-cycle bus-rate clock enable is high.

Top module: `cnt_interval_timer`

## Requirements
- R1: A bus write with addr[3]=1 is a timer load; addr[1:0] selects the decrement interval: 00 every cycle, 01 every 8, 10 every 64, 11 every 1024 enabled cycles.
- R2: A load puts wdata into the count and restarts the interval phase, so the first decrement happens on the enabled edge N cycles after the load edge, where N is the interval.
- R3: When a decrement takes the count from 0x00, the count becomes 0xFF and the expiry flag is set; while the flag is set the count decrements on every enabled cycle, whatever the programmed interval.
- R4: A count read (addr[3]=0, addr[0]=0, rw=1) or any timer load clears the expiry flag. If that access falls on the same edge as a wraparound, the flag stays set.
- R5: Once the flag clears, counting continues from the value reached, at the last programmed interval. The interval phase keeps running and is not reset by the clear.
- R6: A status read (addr[3]=0, addr[0]=1, rw=1) returns the flag in bit 7 and zeros in bits 6..0, and does not clear the flag. rdata shows the count whenever the status address is not selected.
- R7: addr[2] of each timer load or count read is latched as the interrupt enable. irq_n is 0 exactly when the enable is 1 and the flag is set; otherwise it is 1.
- R8: Reset clears the flag and the interrupt enable, selects the 1024-cycle interval, and loads the count with 0xFF.
- R9: On cycles with cyc_en=0 the count, the flag and the interval phase hold, and bus accesses have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| cyc_en | input | 1 | One-cycle bus-rate enable; gates decrements and accesses |
| cs | input | 1 | Chip select |
| rw | input | 1 | 1 = read, 0 = write |
| addr | input | 4 | [3] load region, [2] interrupt-enable variant, [1:0] interval on loads, [0] status select on reads |
| wdata | input | 8 | Load value |
| rdata | output | 8 | Count or status byte, combinational from the address |
| irq_n | output | 1 | Active-low interrupt request |

## Verification
Read data is combinational, so the bench samples it on the falling edge of the cycle in which the read is driven. That value reflects every rising edge up to the preceding one. A load or acknowledge driven in cycle k takes effect on edge k+1. After a load with interval N, the count seen in slot s is the load value minus floor(s/N) until the wrap. The flag and irq_n change on the edge after the wrap or the acknowledge. The driver queues each expected value together with the slot it is due in, and the monitor compares it on that falling edge. Waits are counted in whole cycles from the load edge, so every check lands on a known phase of the interval.

// File: rtl/ivt_pkg.sv
package ivt_pkg;
  localparam int CNT_W  = 8;
  localparam int ADDR_W = 4;
  localparam int SHIFT_MAX = 10;
  localparam int PRE_W  = SHIFT_MAX;

  typedef enum logic [1:0] {
    DIV_1    = 2'b00,
    DIV_8    = 2'b01,
    DIV_64   = 2'b10,
    DIV_1024 = 2'b11
  } div_e;

  function automatic logic [PRE_W-1:0] div_limit(input div_e sel);
    int unsigned sh;
    case (sel)
      DIV_1:   sh = 0;
      DIV_8:   sh = 3;
      DIV_64:  sh = 6;
      default: sh = SHIFT_MAX;
    endcase
    div_limit = PRE_W'((32'd1 << sh) - 32'd1);
  endfunction
endpackage

// File: rtl/ivt_decode.sv
module ivt_decode
  import ivt_pkg::*;
(
  input  logic              cs,
  input  logic              cyc_en,
  input  logic              rw,
  input  logic [ADDR_W-1:0] addr,
  output logic              load_stb,
  output logic              cnt_rd_stb,
  output logic              stat_sel,
  output logic              irq_sel,
  output div_e              div_sel
);
  logic acc;

  always_comb begin
    acc        = cs & cyc_en;
    load_stb   = acc & ~rw & addr[3];
    cnt_rd_stb = acc & rw & ~addr[3] & ~addr[0];
    stat_sel   = ~addr[3] & addr[0];
    irq_sel    = addr[2];
    div_sel    = div_e'(addr[1:0]);
  end
endmodule

// File: rtl/ivt_prescale.sv
module ivt_prescale
  import ivt_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic cyc_en,
  input  logic restart,
  input  div_e div_new,
  output logic tick
);
  logic [PRE_W-1:0] phase_q, phase_d;
  div_e             div_q, div_d;

  always_comb begin
    tick    = (phase_q == div_limit(div_q));
    phase_d = phase_q;
    div_d   = div_q;
    if (restart) begin
      phase_d = '0;
      div_d   = div_new;
    end else if (cyc_en) begin
      phase_d = tick ? '0 : phase_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= '0;
      div_q   <= DIV_1024;
    end else begin
      phase_q <= phase_d;
      div_q   <= div_d;
    end
  end
endmodule

// File: rtl/ivt_counter.sv
module ivt_counter
  import ivt_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cyc_en,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             clr_req,
  input  logic             tick,
  output logic [CNT_W-1:0] cnt_q,
  output logic             flag_q,
  output logic             dec
);
  logic [CNT_W-1:0] cnt_d;
  logic             flag_d;
  logic             wrap;

  always_comb begin
    dec  = flag_q | tick;
    wrap = cyc_en & dec & (cnt_q == '0);
    cnt_d = cnt_q;
    if (cyc_en & load)
      cnt_d = load_val;
    else if (cyc_en & dec)
      cnt_d = cnt_q - 1'b1;
    if (wrap)
      flag_d = 1'b1;
    else if (clr_req)
      flag_d = 1'b0;
    else
      flag_d = flag_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '1;
      flag_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      flag_q <= flag_d;
    end
  end
endmodule

// File: rtl/cnt_interval_timer.sv
module cnt_interval_timer
  import ivt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cyc_en,
  input  logic              cs,
  input  logic              rw,
  input  logic [ADDR_W-1:0] addr,
  input  logic [CNT_W-1:0]  wdata,
  output logic [CNT_W-1:0]  rdata,
  output logic              irq_n
);
  logic [1:0]       rst_sync_q;
  logic             rst_int_n;
  logic             load_stb, cnt_rd_stb, stat_sel, irq_sel;
  div_e             div_sel;
  logic             tick, dec;
  logic [CNT_W-1:0] cnt_q;
  logic             flag_q;
  logic             irq_en_q, irq_en_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  ivt_decode u_dec (
    .cs(cs), .cyc_en(cyc_en), .rw(rw), .addr(addr),
    .load_stb(load_stb), .cnt_rd_stb(cnt_rd_stb),
    .stat_sel(stat_sel), .irq_sel(irq_sel), .div_sel(div_sel)
  );

  ivt_prescale u_pre (
    .clk(clk), .rst_n(rst_int_n), .cyc_en(cyc_en),
    .restart(load_stb), .div_new(div_sel), .tick(tick)
  );

  ivt_counter u_cnt (
    .clk(clk), .rst_n(rst_int_n), .cyc_en(cyc_en),
    .load(load_stb), .load_val(wdata),
    .clr_req(load_stb | cnt_rd_stb), .tick(tick),
    .cnt_q(cnt_q), .flag_q(flag_q), .dec(dec)
  );

  always_comb begin
    irq_en_d = (load_stb | cnt_rd_stb) ? irq_sel : irq_en_q;
    rdata    = stat_sel ? {flag_q, {(CNT_W-1){1'b0}}} : cnt_q;
    irq_n    = ~(irq_en_q & flag_q);
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) irq_en_q <= 1'b0;
    else            irq_en_q <= irq_en_d;
  end
endmodule

// File: rtl/ivt_checker.sv
module ivt_checker
  import ivt_pkg::*;
(
  input logic             clk,
  input logic             rst_int_n,
  input logic             cyc_en,
  input logic             cs,
  input logic             rw,
  input logic             a_load,
  input logic             a_irq,
  input logic             a_stat,
  input logic             irq_n,
  input logic [CNT_W-1:0] cnt,
  input logic             flag,
  input logic             dec
);
  logic wr_acc, crd_acc, srd_acc, wrap_now;
  assign wr_acc   = cs & cyc_en & ~rw & a_load;
  assign crd_acc  = cs & cyc_en & rw & ~a_load & ~a_stat;
  assign srd_acc  = cs & cyc_en & rw & ~a_load & a_stat;
  assign wrap_now = cyc_en & dec & (cnt == '0);

  AST_GATED_HOLD: assert property (@(posedge clk) disable iff (!rst_int_n)
    !cyc_en |=> ($stable(cnt) && $stable(flag))); // R9

  AST_WRAP_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_int_n)
    wrap_now |=> flag); // R3

  AST_FAST_WHILE_FLAG: assert property (@(posedge clk) disable iff (!rst_int_n)
    (flag && cyc_en && !wr_acc) |=> (cnt == ($past(cnt) - 8'd1))); // R3

  AST_STATUS_KEEPS_FLAG: assert property (@(posedge clk) disable iff (!rst_int_n)
    (srd_acc && flag) |=> flag); // R6

  AST_COUNT_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_int_n)
    (crd_acc && !wrap_now) |=> !flag); // R4

  AST_IRQ_DISABLED: assert property (@(posedge clk) disable iff (!rst_int_n)
    ((wr_acc || crd_acc) && !a_irq) |=> irq_n); // R7
endmodule

bind cnt_interval_timer ivt_checker u_chk (
  .clk(clk), .rst_int_n(rst_int_n), .cyc_en(cyc_en), .cs(cs), .rw(rw),
  .a_load(addr[3]), .a_irq(addr[2]), .a_stat(addr[0]), .irq_n(irq_n),
  .cnt(cnt_q), .flag(flag_q), .dec(dec)
);

// File: tb/tb_cnt_interval_timer.sv
module tb_cnt_interval_timer;
  logic       clk, rst_n, cyc_en, cs, rw;
  logic [3:0] addr;
  logic [7:0] wdata, rdata;
  logic       irq_n;
  logic       probe;
  int         checks, errors;
  bit         finished;

  typedef struct {
    bit       is_irq;
    bit [7:0] exp;
    string    tag;
  } item_t;
  item_t sb[$];

  localparam logic [3:0] W1 = 4'b1000, W8 = 4'b1001, W64 = 4'b1010, W1K = 4'b1011;
  localparam logic [3:0] WI1 = 4'b1100;
  localparam logic [3:0] RC = 4'b0000, RS = 4'b0001;

  cnt_interval_timer dut (
    .clk(clk), .rst_n(rst_n), .cyc_en(cyc_en), .cs(cs), .rw(rw),
    .addr(addr), .wdata(wdata), .rdata(rdata), .irq_n(irq_n)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  always @(negedge clk) begin
    if (probe) begin
      if (sb.size() == 0) begin
        checks++; errors++;
        $display("FAIL scoreboard: got %02h expected <queued item>", rdata);
      end else begin
        item_t it;
        logic [7:0] act;
        it  = sb.pop_front();
        act = it.is_irq ? {7'b0, irq_n} : rdata;
        checks++;
        if (act !== it.exp) begin
          errors++;
          $display("FAIL %s: got %02h expected %02h", it.tag, act, it.exp);
        end
      end
    end
  end

  task automatic bus_write(input logic [3:0] a, input logic [7:0] d, input logic e);
    @(posedge clk); #1;
    cs = 1'b1; rw = 1'b0; addr = a; wdata = d; cyc_en = e; probe = 1'b0;
  endtask

  task automatic bus_read(input logic [3:0] a, input logic [7:0] exp, input string tag);
    item_t it;
    it.is_irq = 1'b0; it.exp = exp; it.tag = tag;
    sb.push_back(it);
    @(posedge clk); #1;
    cs = 1'b1; rw = 1'b1; addr = a; cyc_en = 1'b1; probe = 1'b1;
  endtask

  task automatic irq_probe(input logic exp, input string tag);
    item_t it;
    it.is_irq = 1'b1; it.exp = {7'b0, exp}; it.tag = tag;
    sb.push_back(it);
    @(posedge clk); #1;
    cs = 1'b0; cyc_en = 1'b1; probe = 1'b1;
  endtask

  task automatic idle(input int n, input logic e);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
      cs = 1'b0; cyc_en = e; probe = 1'b0;
    end
  endtask

  // First write absorbs any pending wrap; timing is counted from the second.
  task automatic fresh_load(input logic [3:0] a, input logic [7:0] d);
    bus_write(W1K, 8'h80, 1'b1);
    bus_write(a, d, 1'b1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    checks = 0; errors = 0; finished = 1'b0;
    rst_n = 1'b0; cyc_en = 1'b1; cs = 1'b0; rw = 1'b1;
    addr = 4'h0; wdata = 8'h00; probe = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    idle(4, 1'b1);

    // R8 reset state
    bus_read(RS, 8'h00, "R8 status after reset");
    bus_read(RC, 8'hFF, "R8 count after reset");
    irq_probe(1'b1, "R8 irq_n after reset");

    // R1 every-cycle interval
    fresh_load(W1, 8'd5); idle(3, 1'b1);
    bus_read(RC, 8'd2, "R1 interval 1");

    // R1/R2 interval 8
    fresh_load(W8, 8'd10); idle(20, 1'b1);
    bus_read(RC, 8'd8, "R1 interval 8");
    fresh_load(W8, 8'd10); idle(7, 1'b1);
    bus_read(RC, 8'd10, "R2 no decrement before N cycles");
    bus_read(RC, 8'd9, "R2 first decrement at N cycles");

    // R1 interval 64 and 1024
    fresh_load(W64, 8'd3); idle(63, 1'b1);
    bus_read(RC, 8'd3, "R1 interval 64 before edge");
    bus_read(RC, 8'd2, "R1 interval 64 at edge");
    fresh_load(W1K, 8'd7); idle(1023, 1'b1);
    bus_read(RC, 8'd7, "R1 interval 1024 before edge");
    bus_read(RC, 8'd6, "R1 interval 1024 at edge");

    // R3 R4 R5 R6 expiry, fast counting, acknowledge, return to interval
    fresh_load(W8, 8'd0); idle(10, 1'b1);
    bus_read(RS, 8'h80, "R3 flag set after wrap");
    bus_read(RS, 8'h80, "R6 status read keeps flag");
    bus_read(RC, 8'hFB, "R3 every-cycle decrement after wrap");
    bus_read(RS, 8'h00, "R4 count read clears flag");
    bus_read(RC, 8'hFA, "R5 holds between interval edges");
    bus_read(RC, 8'hFA, "R5 still held");
    bus_read(RC, 8'hF9, "R5 resumes at interval phase");

    // R4 count read on the wrap edge
    fresh_load(W1, 8'd2); idle(2, 1'b1);
    bus_read(RC, 8'h00, "R4 count before wrap");
    bus_read(RS, 8'h80, "R4 read on wrap edge keeps flag");
    bus_read(RC, 8'hFE, "R3 fast count after wrap");

    // R4 load on the wrap edge
    fresh_load(W8, 8'd0); idle(7, 1'b1);
    bus_write(W8, 8'h40, 1'b1);
    bus_read(RS, 8'h80, "R4 load on wrap edge keeps flag");
    bus_read(RC, 8'h3F, "R4 loaded value counts fast");

    // R7 interrupt output
    fresh_load(WI1, 8'd1); idle(1, 1'b1);
    irq_probe(1'b1, "R7 irq_n high before expiry");
    irq_probe(1'b0, "R7 irq_n low on expiry");
    bus_read(RS, 8'h80, "R7 status shows flag");
    irq_probe(1'b0, "R7 irq_n stays low after status read");
    bus_read(RC, 8'hFC, "R7 count at acknowledge");
    irq_probe(1'b1, "R7 irq_n released after plain count read");

    // R9 clock enable gating
    fresh_load(W1, 8'd20); idle(3, 1'b0);
    bus_write(W1, 8'd99, 1'b0);
    idle(6, 1'b0);
    bus_read(RC, 8'd20, "R9 no decrement or load while disabled");
    bus_read(RC, 8'd19, "R9 decrement resumes when enabled");

    idle(3, 1'b1);
    if (sb.size() != 0) begin
      checks++; errors++;
      $display("FAIL scoreboard: got %0d pending expected 0", sb.size());
    end
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule